// File: doc/BRIEF.md
# Round-Robin Entropy Block Collector

This block sits between a set of entropy sources and a hash mixer. Each source offers 32-bit words over a valid/ready handshake. The collector serves the sources in a fixed rotation and takes one word per turn. All the words it takes form a single continuous message, which it cuts into 1024-bit blocks of 32 words. A finished block goes to the hash over a second valid/ready handshake. The block is held there until the hash accepts it, and only then does filling of the next block begin.

Slot order is fixed: the external sources come first, by index, and an optional extra slot comes after them. That extra slot carries words fed back from the downstream generator. If the slot whose turn it is has nothing to offer, the collector waits on that slot and does not skip it. As a result the interleaving is always the same, and no single source can fill a block by itself.

Top module: `ecollect_top`

## Requirements
- R1: After reset `blockValid` is low and only slot 0 sees its ready signal high.
- R2: At most one slot is ready at any time. The turn starts at slot 0 and advances by one slot after each accepted word. It wraps from the last slot back to slot 0. Slots 0..NUM_SRC-1 are `srcReady[i]`, and the feedback slot (index NUM_SRC) is `fbReady`.
- R3: While the slot whose turn it is offers no valid word, that slot keeps the turn and no other slot becomes ready.
- R4: `blockValid` goes high on the clock edge that accepts the 32nd word of a block, where 32 = BLOCK_W/WORD_W.
- R5: The first word accepted for a block sits in `blockData[1023:992]`. Each later word sits in the next lower 32 bits, and the last word sits in `blockData[31:0]`.
- R6: Once high, `blockValid` stays high and `blockData` stays unchanged until an edge where `blockReady` is high. That edge clears `blockValid`.
- R7: While `blockValid` is high, no slot is ready, so collection is paused.
- R8: The rotation continues across block boundaries. The first word of a new block comes from the slot after the one that supplied the last word of the previous block.
- R9: With FB_EN set, the feedback slot takes part in the rotation like any other source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| srcData | input | NUM_SRC*32 | Source words, slot i in bits [32i+31:32i] |
| srcValid | input | NUM_SRC | Source word valid, one per source |
| srcReady | output | NUM_SRC | Source word taken this cycle when valid |
| fbData | input | 32 | Feedback word from the generator |
| fbValid | input | 1 | Feedback word valid |
| fbReady | output | 1 | Feedback word taken when valid |
| blockData | output | 1024 | Assembled message block |
| blockValid | output | 1 | Block complete and waiting |
| blockReady | input | 1 | Hash accepts the block |

## Verification
The hardest case to reach is a pause that lands where the rotation meets a block boundary. A block completes, the hash holds off, and collection then has to resume on the correct slot. That slot is not slot 0, because 32 is not a multiple of three slots. Random valid patterns rarely hold this case long enough to matter. The stimulus therefore mixes full-rate phases, phases with the hash held off, and phases that withhold only the slot whose turn it is. The bench model tracks the expected turn every cycle, so each of these situations is checked at the ready outputs.

// File: rtl/ecollect_pkg.sv
package ecollect_pkg;
  localparam int SLOT_IDX_W = 4;

  typedef struct packed {
    logic                  shiftEn;
    logic [SLOT_IDX_W-1:0] slot;
  } ctl_t;
endpackage

// File: rtl/ecollect_dp.sv
module ecollect_dp
  import ecollect_pkg::*;
#(
  parameter int WORD_W  = 32,
  parameter int SLOTS   = 3,
  parameter int BLOCK_W = 1024
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  ctl_t                    ctl,
  input  logic [SLOTS*WORD_W-1:0] wordsIn,
  output logic [BLOCK_W-1:0]      blockData
);
  logic [WORD_W-1:0]  selWord;
  logic [BLOCK_W-1:0] shiftReg;

  always_comb begin
    selWord = '0;
    for (int i = 0; i < SLOTS; i++) begin
      if (ctl.slot == SLOT_IDX_W'(i)) selWord = wordsIn[i*WORD_W +: WORD_W];
    end
  end

  // Oldest word migrates toward the top as new words enter at the bottom.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) shiftReg <= '0;
    else if (ctl.shiftEn) shiftReg <= {shiftReg[BLOCK_W-WORD_W-1:0], selWord};
  end

  assign blockData = shiftReg;
endmodule

// File: rtl/ecollect_ctl.sv
module ecollect_ctl
  import ecollect_pkg::*;
#(
  parameter int SLOTS = 3,
  parameter int WORDS = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [SLOTS-1:0] validAll,
  input  logic             blockReady,
  output logic [SLOTS-1:0] readyAll,
  output logic             blockValid,
  output ctl_t             ctl
);
  localparam int SLOT_W = (SLOTS > 1) ? $clog2(SLOTS) : 1;
  localparam int CNT_W  = $clog2(WORDS);

  logic [SLOT_W-1:0] turn;
  logic [CNT_W-1:0]  wordCnt;
  logic              holdBlk;
  logic              wordTaken;

  assign wordTaken   = !holdBlk && validAll[turn];
  assign readyAll    = holdBlk ? '0 : (SLOTS'(1) << turn);
  assign blockValid  = holdBlk;
  assign ctl.shiftEn = wordTaken;
  assign ctl.slot    = SLOT_IDX_W'(turn);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      turn    <= '0;
      wordCnt <= '0;
      holdBlk <= 1'b0;
    end else begin
      if (wordTaken) begin
        turn <= (turn == SLOT_W'(SLOTS-1)) ? '0 : turn + 1'b1;
        if (wordCnt == CNT_W'(WORDS-1)) begin
          wordCnt <= '0;
          holdBlk <= 1'b1;
        end else begin
          wordCnt <= wordCnt + 1'b1;
        end
      end
      if (holdBlk && blockReady) holdBlk <= 1'b0;
    end
  end
endmodule

// File: rtl/ecollect_top.sv
module ecollect_top
  import ecollect_pkg::*;
#(
  parameter int NUM_SRC = 2,
  parameter int FB_EN   = 1,
  parameter int WORD_W  = 32,
  parameter int BLOCK_W = 1024
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic [NUM_SRC*WORD_W-1:0] srcData,
  input  logic [NUM_SRC-1:0]        srcValid,
  output logic [NUM_SRC-1:0]        srcReady,
  input  logic [WORD_W-1:0]         fbData,
  input  logic                      fbValid,
  output logic                      fbReady,
  output logic [BLOCK_W-1:0]        blockData,
  output logic                      blockValid,
  input  logic                      blockReady
);
  localparam int SLOTS = NUM_SRC + ((FB_EN != 0) ? 1 : 0);
  localparam int WORDS = BLOCK_W / WORD_W;

  logic [SLOTS-1:0]        validAll;
  logic [SLOTS-1:0]        readyAll;
  logic [SLOTS*WORD_W-1:0] wordsAll;
  ctl_t                    ctl;

  generate
    if (FB_EN != 0) begin : g_fb
      assign validAll = {fbValid, srcValid};
      assign wordsAll = {fbData, srcData};
      assign fbReady  = readyAll[NUM_SRC];
    end else begin : g_nofb
      assign validAll = srcValid;
      assign wordsAll = srcData;
      assign fbReady  = 1'b0;
    end
  endgenerate

  assign srcReady = readyAll[NUM_SRC-1:0];

  ecollect_ctl #(.SLOTS(SLOTS), .WORDS(WORDS)) u_ctl (
    .clk(clk), .rstN(rstN), .validAll(validAll), .blockReady(blockReady),
    .readyAll(readyAll), .blockValid(blockValid), .ctl(ctl)
  );

  ecollect_dp #(.WORD_W(WORD_W), .SLOTS(SLOTS), .BLOCK_W(BLOCK_W)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .wordsIn(wordsAll), .blockData(blockData)
  );
endmodule

// File: rtl/ecollect_chk.sv
module ecollect_chk #(
  parameter int SLOTS   = 3,
  parameter int BLOCK_W = 1024
) (
  input logic               clk,
  input logic               rstN,
  input logic [SLOTS-1:0]   validAll,
  input logic [SLOTS-1:0]   readyAll,
  input logic               blockValid,
  input logic               blockReady,
  input logic [BLOCK_W-1:0] blockData
);
  // R2
  one_turn_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(readyAll));

  // R7
  pause_while_full_chk: assert property (@(posedge clk) disable iff (!rstN)
    blockValid |-> (readyAll == '0));

  // R6
  hold_block_chk: assert property (@(posedge clk) disable iff (!rstN)
    (blockValid && !blockReady) |=> (blockValid && $stable(blockData)));

  // R3
  stall_turn_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((readyAll != '0) && ((readyAll & validAll) == '0)) |=> (readyAll == $past(readyAll)));

  // R6
  release_block_chk: assert property (@(posedge clk) disable iff (!rstN)
    (blockValid && blockReady) |=> !blockValid);
endmodule

bind ecollect_top ecollect_chk #(.SLOTS(SLOTS), .BLOCK_W(BLOCK_W)) u_chk (
  .clk(clk), .rstN(rstN), .validAll(validAll), .readyAll(readyAll),
  .blockValid(blockValid), .blockReady(blockReady), .blockData(blockData)
);

// File: tb/ecollect_top_tb.sv
module ecollect_top_tb;
  localparam int NS = 2;
  localparam int SL = 3;
  localparam int WPB = 32;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [31:0] word [SL];
  logic valid [SL];
  logic blockReady = 1'b0;
  logic [NS*32-1:0] srcData;
  logic [NS-1:0] srcValid, srcReady;
  logic fbReady;
  logic [1023:0] blockData;
  logic blockValid;

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  assign srcData  = {word[1], word[0]};
  assign srcValid = {valid[1], valid[0]};

  ecollect_top u_dut (
    .clk(clk), .rstN(rstN), .srcData(srcData), .srcValid(srcValid),
    .srcReady(srcReady), .fbData(word[2]), .fbValid(valid[2]), .fbReady(fbReady),
    .blockData(blockData), .blockValid(blockValid), .blockReady(blockReady)
  );

  task automatic check(input bit ok, input string tag, input logic [1023:0] act,
                       input logic [1023:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [SL-1:0] expReady(input bit full, input int t);
    return full ? '0 : SL'(1) << t;
  endfunction

  task automatic finishRun();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        checks++; fails++;
        $display("FAIL watchdog actual=%0d expected=done", cyc);
        finishRun();
      end
    end
  end

  initial begin
    int turn = 0;
    int cnt = 0;
    bit full = 1'b0;
    bit justFreed;
    int blocks = 0;
    int fbTaken = 0;
    logic [1023:0] expBlock = '0;
    logic [SL-1:0] rdy;
    bit acc [SL];
    void'($urandom(32'd4711));
    for (int s = 0; s < SL; s++) begin word[s] = $urandom; valid[s] = 1'b0; end
    repeat (3) @(negedge clk);
    // R1: reset state
    check(blockValid == 1'b0, "R1 blockValid", 1024'(blockValid), 1024'(0));
    check({fbReady, srcReady} == 3'b001, "R1 ready", 1024'({fbReady, srcReady}), 1024'(1));
    rstN = 1'b1;
    for (int k = 0; k < 6000; k++) begin
      int mode;
      mode = (k < 250) ? 1 : (k < 350) ? 2 : (k < 600) ? 3 : (k < 700) ? 1 :
             (k >= 2000 && k < 2100) ? 2 : 0;
      // drive inputs for the coming edge
      for (int s = 0; s < SL; s++) begin
        case (mode)
          1, 3: valid[s] = 1'b1;
          2: valid[s] = (s != turn);
          default: if (!valid[s]) valid[s] = ($urandom % 2) == 0;
        endcase
      end
      blockReady = (mode == 1) ? 1'b1 : (mode == 3) ? 1'b0 : (($urandom % 3) == 0);
      @(negedge clk);
      // model the edge just passed using the applied inputs
      justFreed = 1'b0;
      for (int s = 0; s < SL; s++) acc[s] = 1'b0;
      if (full) begin
        if (blockReady) begin full = 1'b0; justFreed = 1'b1; end
      end else if (valid[turn]) begin
        acc[turn] = 1'b1;
        expBlock = {expBlock[991:0], word[turn]};
        if (turn == NS) fbTaken++;
        turn = (turn + 1) % SL;
        cnt++;
        if (cnt == WPB) begin cnt = 0; full = 1'b1; blocks++; end
      end
      // compare outputs
      rdy = {fbReady, srcReady};
      check(blockValid == full, "R4 blockValid", 1024'(blockValid), 1024'(full));
      if (full)
        check(rdy == '0, "R7 ready while full", 1024'(rdy), 1024'(0));
      else if (justFreed)
        check(rdy == expReady(0, turn), "R8 turn after block", 1024'(rdy),
              1024'(expReady(0, turn)));
      else if (mode == 2)
        check(rdy == expReady(0, turn), "R3 stall", 1024'(rdy), 1024'(expReady(0, turn)));
      else
        check(rdy == expReady(0, turn), "R2 rotation", 1024'(rdy), 1024'(expReady(0, turn)));
      if (full)
        check(blockData == expBlock, (cnt == 0 && acc[(turn + SL - 1) % SL]) ?
              "R5 block layout" : "R6 block held", blockData, expBlock);
      // refresh words that were taken
      for (int s = 0; s < SL; s++) begin
        if (acc[s]) begin
          word[s] = $urandom;
          if (mode == 0) valid[s] = ($urandom % 2) == 0;
        end
      end
    end
    // R9: feedback slot contributed words
    check(fbTaken > 0, "R9 feedback used", 1024'(fbTaken), 1024'(1));
    check(blocks > 10, "R4 blocks completed", 1024'(blocks), 1024'(11));
    done = 1'b1;
    finishRun();
  end
endmodule